// File: doc/BRIEF.md
# Six-Channel Programmable Event Timer

This block holds a bank of independent up-counting timer channels behind a small memory-mapped register window. Each channel has a control word, a tick-source word, a readable counter and a compare value. A channel can stop after one match, reload and count again, or run freely and wrap. A match sets a pending bit for that channel. One enable mask passes these bits to a single interrupt line, and writing ones to an acknowledge word clears them.

Two tick-enable inputs drive the counters. One is a fast system tick and the other is a slow low-frequency tick. Each channel picks one of them and can halve its rate. The bus is a single-cycle write strobe with an address and write data. Read data is combinational from the address. Clock generation and bus bridging are done outside the block.

Top module: `tmr_bank`

## Requirements
- R1: Channel n (1..6) uses offsets 0x10·n (control), +0x4 (tick source), +0x8 (counter, read-only) and +0xC (compare). Control reads back enable at bit 0 and mode at bits [5:4]. The tick-source word reads back bits 4 and 0. Compare stores CNT_W bits. A write to the counter offset is ignored. Everything resets to zero.
- R2: An enabled channel adds one to its counter on each tick it accepts. A disabled channel holds its counter.
- R3: Writing 1 to control bit 1 sets the counter to zero in that cycle, and the bit reads back as 0. If enable is written in the same word, the first accepted tick after the write gives a count of 1.
- R4: Tick-source bit 4 = 0 selects the fast tick. Bit 4 = 1 selects the slow tick. Ticks from the other input have no effect.
- R5: Tick-source bit 0 = 1 accepts only every second selected tick, counted from the last clear.
- R6: Mode 0 (one-shot): when the counter reaches the compare value, the channel sets its pending bit, clears its own enable bit and holds the counter at the compare value.
- R7: Mode 1 (repeat): when the counter reaches the compare value, the channel sets its pending bit, reloads zero and keeps counting. The period is therefore the compare value in ticks.
- R8: Mode 3 (free-run), and the unused mode 2: the counter wraps from all-ones to zero and keeps running through matches. A match still sets the pending bit.
- R9: Pending bits are set on a match whatever the interrupt mask holds. They read at offset 0x08, with bit n-1 for channel n.
- R10: Writing offset 0x08 clears each pending bit whose data bit is 1. Zero bits have no effect. A match in the same cycle as its clear leaves the bit set.
- R11: The mask at offset 0x00 (bit n-1 for channel n) is readable. The irq output is the OR over channels of pending AND mask.
- R12: Channels are independent. Writing or clearing one channel does not change another channel's counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fast_tick | input | 1 | System-rate tick enable |
| slow_tick | input | 1 | Low-frequency tick enable |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W (7) | Byte address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for bus_addr, combinational |
| irq | output | 1 | Masked interrupt request |

## Verification
The hardest event to reach from the ports is the free-run wrap, because a full-width counter needs four billion ticks to get there. The bench builds the block with an 8-bit counter, so 258 fast ticks carry a channel through the wrap and through a match on compare value zero. The second hard event is a match and its acknowledge landing in the same cycle. The bench forces this by running a repeat channel with a compare value of 1, so every tick is a match, and then driving one tick together with the acknowledge write on the same edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [1:0] {
        MODE_ONCE = 2'd0,
        MODE_LOOP = 2'd1,
        MODE_RSVD = 2'd2,
        MODE_FREE = 2'd3
    } tmr_mode_e;

    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_CLR_BIT = 1;
    localparam int CTRL_MODE_LO = 4;
    localparam int SRC_SEL_BIT  = 4;
    localparam int SRC_DIV_BIT  = 0;

    localparam logic [1:0] W_CTRL = 2'd0;
    localparam logic [1:0] W_SRC  = 2'd1;
    localparam logic [1:0] W_CNT  = 2'd2;
    localparam logic [1:0] W_CMP  = 2'd3;
    localparam logic [1:0] W_MASK = 2'd0;
    localparam logic [1:0] W_PEND = 2'd2;
endpackage

// File: rtl/tmr_tick_sel.sv
module tmr_tick_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic fast_tick,
    input  logic slow_tick,
    input  logic src_slow,
    input  logic div2,
    input  logic restart,
    output logic adv
);
    typedef struct packed {
        logic phase;
    } st_t;

    st_t  q, d;
    logic src_tick;

    always_comb begin
        d        = q;
        adv      = 1'b0;
        src_tick = src_slow ? slow_tick : fast_tick;
        if (restart) begin
            d.phase = 1'b0;
        end else if (src_tick) begin
            if (!div2) begin
                adv = 1'b1;
            end else begin
                adv     = q.phase;
                d.phase = ~q.phase;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R5: halved rate never accepts two ticks back to back
    p_div2_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (div2 && adv && $stable(div2)) |=> !adv);
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fast_tick,
    input  logic              slow_tick,
    input  logic              wr_ctrl,
    input  logic              wr_src,
    input  logic              wr_cmp,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctrl_rd,
    output logic [DATA_W-1:0] src_rd,
    output logic [DATA_W-1:0] cnt_rd,
    output logic [DATA_W-1:0] cmp_rd,
    output logic              hit
);
    typedef struct packed {
        logic             en;
        tmr_mode_e        mode;
        logic             src;
        logic             div;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] cmp;
    } st_t;

    st_t              q, d;
    logic             clr;
    logic             adv;
    logic [CNT_W-1:0] nxt;

    assign clr = wr_ctrl && wdata[CTRL_CLR_BIT];

    tmr_tick_sel u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .fast_tick (fast_tick),
        .slow_tick (slow_tick),
        .src_slow  (q.src),
        .div2      (q.div),
        .restart   (clr),
        .adv       (adv)
    );

    always_comb begin
        d   = q;
        hit = 1'b0;
        nxt = q.cnt + 1'b1;
        if (wr_ctrl) begin
            d.en   = wdata[CTRL_EN_BIT];
            d.mode = tmr_mode_e'(wdata[CTRL_MODE_LO +: 2]);
        end
        if (wr_src) begin
            d.src = wdata[SRC_SEL_BIT];
            d.div = wdata[SRC_DIV_BIT];
        end
        if (wr_cmp) d.cmp = wdata[CNT_W-1:0];
        if (clr) begin
            d.cnt = '0;
        end else if (q.en && adv) begin
            d.cnt = nxt;
            if (nxt == q.cmp) begin
                hit = 1'b1;
                case (q.mode)
                    MODE_ONCE: d.en  = 1'b0;
                    MODE_LOOP: d.cnt = '0;
                    default:   d.cnt = nxt;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        ctrl_rd                      = '0;
        ctrl_rd[CTRL_EN_BIT]         = q.en;
        ctrl_rd[CTRL_MODE_LO +: 2]   = q.mode;
        src_rd                       = '0;
        src_rd[SRC_SEL_BIT]          = q.src;
        src_rd[SRC_DIV_BIT]          = q.div;
        cnt_rd                       = '0;
        cnt_rd[CNT_W-1:0]            = q.cnt;
        cmp_rd                       = '0;
        cmp_rd[CNT_W-1:0]            = q.cmp;
    end

    // R2: a disabled channel without a clear keeps its count
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.en && !clr) |=> $stable(q.cnt));
    // R3: clear zeroes the counter on the next edge
    p_clr_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (q.cnt == '0));
    // R4: no selected tick, no change
    p_no_tick_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !(q.src ? slow_tick : fast_tick)) |=> $stable(q.cnt));
    // R6: one-shot drops its enable after the match
    p_once_stops_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && q.mode == MODE_ONCE) |=> !q.en);
    // R7: repeat reloads zero after the match
    p_loop_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && q.mode == MODE_LOOP) |=> (q.cnt == '0));
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fast_tick,
    input  logic              slow_tick,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    localparam int WIN_W = ADDR_W - 4;

    typedef struct packed {
        logic [NUM_CH-1:0] mask;
        logic [NUM_CH-1:0] pend;
    } st_t;

    st_t               q, d;
    logic [WIN_W-1:0]  win;
    logic [1:0]        wsel;
    logic              glb_wr;
    logic              pend_wr;
    logic [NUM_CH-1:0] hit;
    logic [DATA_W-1:0] ctrl_rd [NUM_CH];
    logic [DATA_W-1:0] src_rd  [NUM_CH];
    logic [DATA_W-1:0] cnt_rd  [NUM_CH];
    logic [DATA_W-1:0] cmp_rd  [NUM_CH];

    assign win     = bus_addr[ADDR_W-1:4];
    assign wsel    = bus_addr[3:2];
    assign glb_wr  = bus_wr && (win == '0);
    assign pend_wr = glb_wr && (wsel == W_PEND);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic sel;
        assign sel = bus_wr && (win == WIN_W'(g + 1));

        tmr_chan #(
            .CNT_W  (CNT_W),
            .DATA_W (DATA_W)
        ) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .fast_tick (fast_tick),
            .slow_tick (slow_tick),
            .wr_ctrl   (sel && wsel == W_CTRL),
            .wr_src    (sel && wsel == W_SRC),
            .wr_cmp    (sel && wsel == W_CMP),
            .wdata     (bus_wdata),
            .ctrl_rd   (ctrl_rd[g]),
            .src_rd    (src_rd[g]),
            .cnt_rd    (cnt_rd[g]),
            .cmp_rd    (cmp_rd[g]),
            .hit       (hit[g])
        );

        // R9: a match always leaves its pending bit set
        p_hit_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
            hit[g] |=> q.pend[g]);
        // R10: a one in the acknowledge clears the bit when no match competes
        p_ack_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_wr && bus_wdata[g] && !hit[g]) |=> !q.pend[g]);
        // R10: pending holds unless acknowledged
        p_pend_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (q.pend[g] && !(pend_wr && bus_wdata[g])) |=> q.pend[g]);
    end

    always_comb begin
        d = q;
        if (glb_wr && wsel == W_MASK) d.mask = bus_wdata[NUM_CH-1:0];
        if (pend_wr)                  d.pend = q.pend & ~bus_wdata[NUM_CH-1:0];
        d.pend = d.pend | hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign irq = |(q.pend & q.mask);

    always_comb begin
        bus_rdata = '0;
        if (win == '0) begin
            case (wsel)
                W_MASK:  bus_rdata[NUM_CH-1:0] = q.mask;
                W_PEND:  bus_rdata[NUM_CH-1:0] = q.pend;
                default: bus_rdata = '0;
            endcase
        end else begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (win == WIN_W'(i + 1)) begin
                    case (wsel)
                        W_CTRL:  bus_rdata = ctrl_rd[i];
                        W_SRC:   bus_rdata = src_rd[i];
                        W_CNT:   bus_rdata = cnt_rd[i];
                        default: bus_rdata = cmp_rd[i];
                    endcase
                end
            end
        end
    end

    // R11: an empty mask keeps the line low
    p_irq_masked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (q.mask == '0) |-> !irq);
endmodule

// File: tb/tb_tmr_bank.sv
module tb_tmr_bank;
    localparam int CW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fast_tick = 1'b0;
    logic        slow_tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    tmr_bank #(.NUM_CH(6), .CNT_W(CW), .DATA_W(32), .ADDR_W(7)) dut (
        .clk(clk), .rst_n(rst_n), .fast_tick(fast_tick), .slow_tick(slow_tick),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    typedef struct packed {
        logic [2:0]  ch;
        logic [1:0]  mode;
        logic        src;
        logic        div;
        logic [7:0]  cmp;
        logic [9:0]  nf;
        logic [9:0]  ns;
        logic [7:0]  ecnt;
        logic        epend;
        logic        een;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{3'd1, 2'd3, 1'b0, 1'b0, 8'd200, 10'd5, 10'd3,  8'd5, 1'b0, 1'b1}, // R2 R4 fast
        '{3'd2, 2'd3, 1'b1, 1'b0, 8'd200, 10'd4, 10'd6,  8'd6, 1'b0, 1'b1}, // R4 slow
        '{3'd3, 2'd3, 1'b0, 1'b1, 8'd200, 10'd7, 10'd0,  8'd3, 1'b0, 1'b1}, // R5
        '{3'd4, 2'd0, 1'b0, 1'b0, 8'd4,   10'd9, 10'd0,  8'd4, 1'b1, 1'b0}, // R6
        '{3'd5, 2'd1, 1'b0, 1'b0, 8'd4,   10'd10, 10'd0, 8'd2, 1'b1, 1'b1}, // R7
        '{3'd6, 2'd0, 1'b1, 1'b1, 8'd3,   10'd0, 10'd10, 8'd3, 1'b1, 1'b0}, // R5 R6
        '{3'd1, 2'd1, 1'b0, 1'b0, 8'd4,   10'd3, 10'd0,  8'd3, 1'b0, 1'b1}, // R7 before match
        '{3'd2, 2'd3, 1'b0, 1'b0, 8'd2,   10'd5, 10'd0,  8'd5, 1'b1, 1'b1}, // R8 runs past match
        '{3'd3, 2'd2, 1'b0, 1'b0, 8'd2,   10'd5, 10'd0,  8'd5, 1'b1, 1'b1}  // R8 unused mode
    };

    task automatic wr(input logic [6:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic ticks(input logic f, input logic s, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            fast_tick = f; slow_tick = s;
            @(negedge clk);
            fast_tick = 1'b0; slow_tick = 1'b0;
        end
    endtask

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [6:0]  base;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 R11: reset state
        rd(7'h00, v); chk("R1 reset mask", v, 0);
        rd(7'h08, v); chk("R1 reset pending", v, 0);
        rd(7'h10, v); chk("R1 reset ctrl", v, 0);
        rd(7'h18, v); chk("R1 reset count", v, 0);
        chk("R11 reset irq", {31'd0, irq}, 0);

        // R1 R3: readback of fields, clear bit reads 0, counter write ignored
        wr(7'h10, 32'h33); rd(7'h10, v); chk("R3 clear reads 0", v, 32'h31);
        wr(7'h14, 32'h11); rd(7'h14, v); chk("R1 source readback", v, 32'h11);
        wr(7'h1C, 32'h1AB); rd(7'h1C, v); chk("R1 compare width", v, 32'hAB);
        wr(7'h10, 32'h02);
        wr(7'h18, 32'h55); rd(7'h18, v); chk("R1 counter write ignored", v, 0);

        // vector table
        for (int i = 0; i < NV; i++) begin
            base = {VEC[i].ch, 4'h0};
            wr(7'h08, 32'h3F);
            wr(base | 7'h4, {27'd0, VEC[i].src, 3'd0, VEC[i].div});
            wr(base | 7'hC, {24'd0, VEC[i].cmp});
            wr(base, {26'd0, VEC[i].mode, 4'b0011});
            ticks(1'b1, 1'b0, int'(VEC[i].nf));
            ticks(1'b0, 1'b1, int'(VEC[i].ns));
            rd(base | 7'h8, v);
            chk($sformatf("R2 vector %0d count", i), v, {24'd0, VEC[i].ecnt});
            rd(7'h08, v);
            chk($sformatf("R9 vector %0d pending", i), {31'd0, v[VEC[i].ch - 1]}, {31'd0, VEC[i].epend});
            rd(base, v);
            chk($sformatf("R6 vector %0d enable", i), {31'd0, v[0]}, {31'd0, VEC[i].een});
        end

        // R12: stopped one-shots hold, repeat channel ran on through later vectors
        rd(7'h48, v); chk("R12 ch4 held", v, 4);
        rd(7'h68, v); chk("R12 ch6 held", v, 3);
        rd(7'h58, v); chk("R12 ch5 kept running", v, 3);

        // R8: wrap through all-ones with compare zero
        wr(7'h20, 0); wr(7'h30, 0); wr(7'h50, 0);
        wr(7'h14, 0); wr(7'h1C, 0); wr(7'h10, 32'h33);
        wr(7'h08, 32'h3F);
        ticks(1'b1, 1'b0, 258);
        rd(7'h18, v); chk("R8 wrap count", v, 2);
        rd(7'h08, v); chk("R8 match at wrap", v, 32'h01);

        // R12: clearing channel 2 leaves channel 1 alone
        wr(7'h20, 32'h02);
        rd(7'h18, v); chk("R12 ch1 untouched", v, 2);
        wr(7'h10, 0);

        // R9 R11: pending without mask, then mask
        chk("R11 masked low", {31'd0, irq}, 0);
        wr(7'h00, 32'h01); rd(7'h00, v); chk("R11 mask readback", v, 1);
        chk("R11 irq raised", {31'd0, irq}, 1);
        wr(7'h00, 32'h02);
        chk("R11 other mask bit", {31'd0, irq}, 0);
        wr(7'h00, 32'h01);

        // R10: zeros have no effect, ones clear
        wr(7'h08, 0); rd(7'h08, v); chk("R10 zero ack", v, 1);
        wr(7'h08, 32'h3F); rd(7'h08, v); chk("R10 ack all", v, 0);
        chk("R11 irq dropped", {31'd0, irq}, 0);

        // R10: match wins over a clear in the same cycle
        wr(7'h14, 0); wr(7'h1C, 1); wr(7'h10, 32'h13);
        wr(7'h08, 32'h3F);
        @(negedge clk);
        fast_tick = 1'b1; bus_wr = 1'b1; bus_addr = 7'h08; bus_wdata = 32'h01;
        @(negedge clk);
        fast_tick = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
        rd(7'h08, v); chk("R10 set beats clear", v, 1);
        wr(7'h10, 0);

        // R3: clear with enable, first tick gives one
        wr(7'h34, 0); wr(7'h3C, 32'd200); wr(7'h30, 32'h33);
        rd(7'h38, v); chk("R3 cleared", v, 0);
        ticks(1'b1, 1'b0, 1);
        rd(7'h38, v); chk("R3 first tick", v, 1);

        summary();
        $finish;
    end
endmodule